// File: doc/BRIEF.md
# NAND Copy-Back Program Sequencer

This block is a host-side controller that relocates one page of a NAND device to another page without moving the page data across the bus. A single request carries a source row and a destination row. The block first issues a page read with no data burst, so the device loads the page into its internal buffer. It then issues a copy-back program aimed at the destination row and finishes by reading the device status byte. It drives the command-latch, address-latch, write-enable and read-enable strobes and an 8-bit I/O bus, and it monitors the ready/busy line.

A copy-back is only legal when the source and destination lie in the same plane. A request whose plane bits differ is refused at once, and no bus cycles are issued. Every destination that has been copied is recorded in a small table of closed pages. A separate query port reports whether a row is closed, which tells the caller that a later partial program to that row is not allowed. An erase notification reopens every recorded page in the erased block. Each busy wait is guarded by a cycle-count timeout.

Top module: `nandcb_copyback`

## Requirements
- R1: After an accepted request, the read phase is four write cycles in this order: command 00h with CLE high, column byte 00h with ALE high, source row low byte with ALE high, and source row high byte with ALE high. Each cycle uses exactly one WE pulse.
- R2: After the last source address byte no RE pulse occurs. The block waits at least T_WB cycles and then waits for ready/busy (high = ready) before it issues anything further.
- R3: The program phase is command 8Ah (CLE), then column 00h, destination row low byte and destination row high byte (ALE), each with one WE pulse.
- R4: After the program busy wait ends, the block issues command 70h and then exactly one RE pulse. Status bit 0 equal to 1 sets `fail`, and 0 clears it.
- R5: When row bit PLANE_BIT (default 5) differs between source and destination, the block pulses `done` with `err_plane` set in the cycle after acceptance, and it issues no WE or RE pulse.
- R6: When ready/busy stays low for BUSY_TIMEOUT cycles of a wait, the block pulses `done` with `err_timeout` set and issues no further bus cycles for that request.
- R7: After a copy-back reaches its status read, a query on the destination row returns `pp_closed`=1 in the next cycle. A query on a row that was not copied returns 0.
- R8: An erase notification clears every closed entry whose block number (row >> PAGE_BITS) matches the erased row's block. Entries in other blocks remain closed.
- R9: Every WE low pulse lasts exactly T_PULSE cycles. CLE and ALE are never high together, WE and RE are never low together, and the I/O driver is off while RE is low.
- R10: A request is accepted only while the block is idle, and a request made during an operation has no effect. `done` is high only while idle. The result flags hold until the next request is accepted.
- R11: After reset WE and RE are high, CLE, ALE and the I/O enable are low, and `done`, `fail`, `err_plane` and `err_timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a copy-back (taken only when idle) |
| req_src | input | ROW_W | Source row address |
| req_dst | input | ROW_W | Destination row address |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Device reported program failure |
| err_plane | output | 1 | Request refused: plane bits differ |
| err_timeout | output | 1 | A busy wait exceeded BUSY_TIMEOUT |
| pp_chk_valid | input | 1 | Partial-program legality query |
| pp_chk_row | input | ROW_W | Row being queried |
| pp_closed | output | 1 | Queried row is closed (next cycle) |
| erase_valid | input | 1 | A block erase has happened |
| erase_row | input | ROW_W | Any row inside the erased block |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | I/O bus value driven by the block |
| nand_io_oe | output | 1 | I/O bus drive enable |
| nand_io_in | input | 8 | I/O bus value from the device |
| nand_rb_n | input | 1 | Ready/busy, low while busy |

## Verification
The main sequence is run with row pairs that have every byte distinct, with rows whose bytes reach 00h and FFh, and with short, medium and long busy periods. Those cases show whether the source and destination bytes have been swapped or taken from the wrong byte lanes, and whether the block waits for ready rather than a fixed delay. Status bytes with bit 0 set and bit 0 clear separate pass from fail. Pairs that differ only in the plane bit, in both directions, exercise the refusal path. A stuck busy line exercises the timeout. Queries on copied rows, neighbouring rows and rows in erased and untouched blocks show the closed-page record, including the block granularity of an erase.

// File: rtl/nandcb_pkg.sv
`timescale 1ns/1ps
package nandcb_pkg;
  localparam logic [7:0] OP_PAGE_READ = 8'h00;
  localparam logic [7:0] OP_CB_PROG   = 8'h8A;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] COL_ZERO     = 8'h00;

  typedef enum logic [1:0] {BC_IDLE, BC_SETUP, BC_PULSE, BC_HOLD} bc_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} sq_state_t;

  typedef struct packed {
    logic       is_cmd;
    logic       is_addr;
    logic       is_read;
    logic [7:0] val;
  } bus_op_t;
endpackage

// File: rtl/nandcb_buscycle.sv
`timescale 1ns/1ps
module nandcb_buscycle
  import nandcb_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  bus_op_t    op,
  output logic       done,
  output logic [7:0] rdata,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  input  logic [7:0] io_in
);
  localparam int TM1  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TMAX = (TM1 > T_HOLD) ? TM1 : T_HOLD;
  localparam int CW   = $clog2(TMAX + 1);

  bc_state_t     st;
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= BC_IDLE;
      cnt    <= '0;
      rd_q   <= 1'b0;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      io_out <= '0;
      io_oe  <= 1'b0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        BC_IDLE: if (start) begin
          cle    <= op.is_cmd;
          ale    <= op.is_addr;
          io_out <= op.val;
          io_oe  <= !op.is_read;
          rd_q   <= op.is_read;
          cnt    <= CW'(T_SETUP - 1);
          st     <= BC_SETUP;
        end
        BC_SETUP: if (cnt == '0) begin
          if (rd_q) re_n <= 1'b0;
          else      we_n <= 1'b0;
          cnt <= CW'(T_PULSE - 1);
          st  <= BC_PULSE;
        end else cnt <= cnt - 1'b1;
        BC_PULSE: if (cnt == '0) begin
          we_n <= 1'b1;
          re_n <= 1'b1;
          if (rd_q) rdata <= io_in;
          cnt <= CW'(T_HOLD - 1);
          st  <= BC_HOLD;
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          cle   <= 1'b0;
          ale   <= 1'b0;
          io_oe <= 1'b0;
          done  <= 1'b1;
          st    <= BC_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));
  // R9
  latch_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
  // R9
  read_drive_off_chk: assert property (@(posedge clk) disable iff (rst) !re_n |-> !io_oe);
  // R9
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> ($stable(io_out) && $stable(cle) && $stable(ale) && io_oe));
endmodule

// File: rtl/nandcb_closed_pages.sv
`timescale 1ns/1ps
module nandcb_closed_pages #(
  parameter int ROW_W     = 16,
  parameter int PAGE_BITS = 5,
  parameter int DEPTH     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rec_valid,
  input  logic [ROW_W-1:0] rec_row,
  input  logic             erase_valid,
  input  logic [ROW_W-1:0] erase_row,
  input  logic             chk_valid,
  input  logic [ROW_W-1:0] chk_row,
  output logic             chk_closed
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ROW_W-1:0] row_q [DEPTH];
  logic [DEPTH-1:0] vld_q, hit, ers;
  logic [PW-1:0]    wptr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = vld_q[i] && (row_q[i] == chk_row);
    assign ers[i] = vld_q[i] && (row_q[i][ROW_W-1:PAGE_BITS] == erase_row[ROW_W-1:PAGE_BITS]);
  end

  always_ff @(posedge clk) begin
    if (rec_valid) row_q[wptr] <= rec_row;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      wptr       <= '0;
      chk_closed <= 1'b0;
    end else begin
      chk_closed <= chk_valid && (|hit);
      if (erase_valid) vld_q <= vld_q & ~ers;
      if (rec_valid) begin
        vld_q[wptr] <= 1'b1;
        wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      end
    end
  end

  // R7
  closed_needs_entry_chk: assert property (@(posedge clk) disable iff (rst)
    chk_closed |-> ($past(chk_valid) && (vld_q != '0 || $past(erase_valid))));
endmodule

// File: rtl/nandcb_copyback.sv
`timescale 1ns/1ps
module nandcb_copyback
  import nandcb_pkg::*;
#(
  parameter int ROW_BYTES    = 2,
  parameter int ROW_W        = 8 * ROW_BYTES,
  parameter int PLANE_BIT    = 5,
  parameter int PAGE_BITS    = 5,
  parameter int CLOSED_DEPTH = 8,
  parameter int T_SETUP      = 2,
  parameter int T_PULSE      = 3,
  parameter int T_HOLD       = 2,
  parameter int T_WB         = 4,
  parameter int BUSY_TIMEOUT = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_src,
  input  logic [ROW_W-1:0] req_dst,
  output logic             done,
  output logic             fail,
  output logic             err_plane,
  output logic             err_timeout,
  input  logic             pp_chk_valid,
  input  logic [ROW_W-1:0] pp_chk_row,
  output logic             pp_closed,
  input  logic             erase_valid,
  input  logic [ROW_W-1:0] erase_row,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb_n
);
  localparam int SA_LAST = 1 + ROW_BYTES;
  localparam int PB      = 2 + ROW_BYTES;
  localparam int PA_LAST = PB + 1 + ROW_BYTES;
  localparam int ST_CMD  = 2 * PB;
  localparam int ST_RD   = 2 * PB + 1;
  localparam int SW      = $clog2(ST_RD + 1);
  localparam int WCW     = $clog2(BUSY_TIMEOUT + 1);

  sq_state_t        st;
  logic [SW-1:0]    step;
  logic [ROW_W-1:0] src_q, dst_q;
  logic [WCW-1:0]   wcnt;
  logic             eng_start, eng_done, rec_valid;
  logic [7:0]       eng_rdata;
  bus_op_t          op;
  int               si;
  logic             plane_bad;

  assign plane_bad = req_src[PLANE_BIT] != req_dst[PLANE_BIT];
  assign si = int'(step);

  always_comb begin
    op = '0;
    if (si == 0) begin
      op.is_cmd = 1'b1; op.val = OP_PAGE_READ;
    end else if (si == 1 || si == PB + 1) begin
      op.is_addr = 1'b1; op.val = COL_ZERO;
    end else if (si <= SA_LAST) begin
      op.is_addr = 1'b1; op.val = src_q[8*(si-2) +: 8];
    end else if (si == PB) begin
      op.is_cmd = 1'b1; op.val = OP_CB_PROG;
    end else if (si <= PA_LAST) begin
      op.is_addr = 1'b1; op.val = dst_q[8*(si-PB-2) +: 8];
    end else if (si == ST_CMD) begin
      op.is_cmd = 1'b1; op.val = OP_STATUS;
    end else begin
      op.is_read = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; step <= '0; src_q <= '0; dst_q <= '0; wcnt <= '0;
      eng_start <= 1'b0; rec_valid <= 1'b0; done <= 1'b0;
      fail <= 1'b0; err_plane <= 1'b0; err_timeout <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      rec_valid <= 1'b0;
      done      <= 1'b0;
      case (st)
        SQ_IDLE: if (req_valid) begin
          fail <= 1'b0; err_timeout <= 1'b0; err_plane <= 1'b0;
          if (plane_bad) begin
            err_plane <= 1'b1;
            done      <= 1'b1;
          end else begin
            src_q <= req_src; dst_q <= req_dst;
            step <= '0; eng_start <= 1'b1; st <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: if (eng_done) begin
          if (si == ST_RD) begin
            fail <= eng_rdata[0]; done <= 1'b1; rec_valid <= 1'b1; st <= SQ_IDLE;
          end else if (si == SA_LAST || si == PA_LAST) begin
            wcnt <= '0; st <= SQ_WAIT;
          end else begin
            step <= step + 1'b1; eng_start <= 1'b1;
          end
        end
        default: begin
          if (wcnt >= WCW'(T_WB) && nand_rb_n) begin
            step <= step + 1'b1; eng_start <= 1'b1; st <= SQ_ISSUE;
          end else if (wcnt == WCW'(BUSY_TIMEOUT)) begin
            err_timeout <= 1'b1; done <= 1'b1; st <= SQ_IDLE;
          end else wcnt <= wcnt + 1'b1;
        end
      endcase
    end
  end

  nandcb_buscycle #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_bus (
    .clk(clk), .rst(rst), .start(eng_start), .op(op), .done(eng_done), .rdata(eng_rdata),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .io_in(nand_io_in)
  );

  nandcb_closed_pages #(.ROW_W(ROW_W), .PAGE_BITS(PAGE_BITS), .DEPTH(CLOSED_DEPTH)) u_closed (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_row(dst_q),
    .erase_valid(erase_valid), .erase_row(erase_row),
    .chk_valid(pp_chk_valid), .chk_row(pp_chk_row), .chk_closed(pp_closed)
  );

  // R5
  plane_block_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && req_valid && plane_bad) |=> (done && err_plane && st == SQ_IDLE && nand_we_n));
  // R2
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_WAIT) |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));
  // R6
  timeout_done_chk: assert property (@(posedge clk) disable iff (rst) $rose(err_timeout) |-> done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> (st == SQ_IDLE));
endmodule

// File: tb/nandcb_copyback_test.sv
`timescale 1ns/1ps
module nandcb_copyback_test;
  localparam int T_PULSE = 3;
  localparam int NVEC = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [15:0] req_src = '0, req_dst = '0;
  logic done, fail, err_plane, err_timeout;
  logic pp_chk_valid = 1'b0, erase_valid = 1'b0;
  logic [15:0] pp_chk_row = '0, erase_row = '0;
  logic pp_closed;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_out, nand_io_in;
  logic rb_q = 1'b1;

  always #2.5 clk = ~clk;

  nandcb_copyback uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_dst(req_dst),
    .done(done), .fail(fail), .err_plane(err_plane), .err_timeout(err_timeout),
    .pp_chk_valid(pp_chk_valid), .pp_chk_row(pp_chk_row), .pp_closed(pp_closed),
    .erase_valid(erase_valid), .erase_row(erase_row),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb_n(rb_q)
  );

  // device stand-in
  logic [9:0] wlog [0:15];
  int wcyc [0:15];
  int wcount = 0, rel_cyc [0:1], rel_n = 0, re_pulses = 0;
  int lo_len = 0, lo_min = 999, lo_max = 0, cyc = 0, busy_cnt = 0, busy_len = 20, addr_n = 0;
  logic [7:0] last_cmd = 8'hFF;
  logic we_q = 1'b1, re_q = 1'b1, stuck = 1'b0, st_fail = 1'b0;

  assign nand_io_in = (!nand_re_n && last_cmd == 8'h70) ? {7'b1100000, st_fail} : 8'h00;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    we_q <= nand_we_n;
    re_q <= nand_re_n;
    if (!rst) begin
      if (!nand_we_n) lo_len = lo_len + 1;
      if (nand_we_n && !we_q) begin
        if (lo_len < lo_min) lo_min = lo_len;
        if (lo_len > lo_max) lo_max = lo_len;
        lo_len = 0;
        if (wcount < 16) begin
          wlog[wcount] = {nand_cle, nand_ale, nand_io_out};
          wcyc[wcount] = cyc;
        end
        wcount = wcount + 1;
        if (nand_cle) begin last_cmd = nand_io_out; addr_n = 0; end
        if (nand_ale) begin
          addr_n = addr_n + 1;
          if (addr_n == 3 && (last_cmd == 8'h00 || last_cmd == 8'h8A)) busy_cnt = busy_len;
        end
      end else if (busy_cnt > 0) begin
        busy_cnt = busy_cnt - 1;
        if (busy_cnt == 0 && rel_n < 2) begin rel_cyc[rel_n] = cyc; rel_n = rel_n + 1; end
      end
      if (!nand_re_n && re_q) re_pulses = re_pulses + 1;
      rb_q <= !(busy_cnt > 0 || stuck);
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_req(input logic [15:0] s, input logic [15:0] d);
    wcount = 0; rel_n = 0; re_pulses = 0; lo_min = 999; lo_max = 0;
    @(negedge clk);
    req_src = s; req_dst = d; req_valid = 1'b1;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) begin got = 1; break; end
    end
  endtask

  task automatic check_log(input logic [15:0] s, input logic [15:0] d);
    logic [9:0] e [0:8];
    e[0] = {2'b10, 8'h00}; e[1] = {2'b01, 8'h00}; e[2] = {2'b01, s[7:0]}; e[3] = {2'b01, s[15:8]};
    e[4] = {2'b10, 8'h8A}; e[5] = {2'b01, 8'h00}; e[6] = {2'b01, d[7:0]}; e[7] = {2'b01, d[15:8]};
    e[8] = {2'b10, 8'h70};
    chk(wcount == 9, "R1 R3 write cycle count", wcount, 9);
    for (int k = 0; k < 4; k++) chk(wlog[k] == e[k], "R1 read phase byte", wlog[k], e[k]);
    for (int k = 4; k < 9; k++) chk(wlog[k] == e[k], "R3 R4 program phase byte", wlog[k], e[k]);
    chk(rel_n == 2 && wcyc[4] > rel_cyc[0], "R2 program waits for ready", wcyc[4], rel_cyc[0]);
    chk(rel_n == 2 && wcyc[8] > rel_cyc[1], "R4 status after program ready", wcyc[8], rel_cyc[1]);
    chk(re_pulses == 1, "R2 R4 single read pulse", re_pulses, 1);
    chk(lo_min == T_PULSE && lo_max == T_PULSE, "R9 WE pulse width", lo_max, T_PULSE);
  endtask

  task automatic query(input logic [15:0] row, input bit exp, input string req);
    @(negedge clk);
    pp_chk_valid = 1'b1; pp_chk_row = row;
    @(negedge clk);
    pp_chk_valid = 1'b0;
    chk(pp_closed == exp, req, pp_closed, exp);
  endtask

  // {src, dst, status_fail, plane_err_expected, busy_len}
  localparam logic [41:0] VEC [NVEC] = '{
    {16'h0020, 16'h0460, 1'b0, 1'b0, 8'd30},
    {16'h1203, 16'h5A1F, 1'b1, 1'b0, 8'd50},
    {16'h00FF, 16'hFFC0, 1'b0, 1'b1, 8'd10},
    {16'hABCD, 16'h1234, 1'b0, 1'b1, 8'd10},
    {16'h7F41, 16'h8042, 1'b0, 1'b0, 8'd5},
    {16'hFFFF, 16'h0020, 1'b0, 1'b0, 8'd100}
  };

  initial begin
    bit got;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe, "R11 strobes idle",
        {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 5'b11000);
    chk(!done && !fail && !err_plane && !err_timeout, "R11 flags clear",
        {done, fail, err_plane, err_timeout}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      st_fail = VEC[v][9];
      busy_len = int'(VEC[v][7:0]);
      start_req(VEC[v][41:26], VEC[v][25:10]);
      wait_done(got);
      chk(got, "R10 done pulse seen", got, 1);
      chk(err_plane == VEC[v][8], "R5 plane error flag", err_plane, VEC[v][8]);
      if (VEC[v][8]) begin
        repeat (30) @(negedge clk);
        chk(wcount == 0 && re_pulses == 0, "R5 no bus cycles on refusal", wcount, 0);
      end else begin
        check_log(VEC[v][41:26], VEC[v][25:10]);
        chk(fail == VEC[v][9], "R4 status bit 0 to fail", fail, VEC[v][9]);
        chk(!err_timeout, "R6 no timeout on normal run", err_timeout, 0);
      end
      @(negedge clk);
      chk(!done, "R10 done lasts one cycle", done, 0);
    end

    // R10 flags hold while idle
    repeat (20) @(negedge clk);
    chk(!fail && !err_plane, "R10 flags hold", {fail, err_plane}, 0);

    // R10 request during an operation is ignored
    st_fail = 1'b1; busy_len = 60;
    start_req(16'h3333, 16'h3C3C);
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    req_src = 16'h0000; req_dst = 16'h0020; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!done && !err_plane, "R10 busy request ignored", {done, err_plane}, 0);
    wait_done(got);
    check_log(16'h3333, 16'h3C3C);
    chk(fail && !err_plane, "R10 first request result kept", {fail, err_plane}, 2'b10);

    // R7 closed pages
    query(16'h0460, 1'b1, "R7 copied row closed");
    query(16'h0461, 1'b0, "R7 neighbour row open");
    query(16'h5A1F, 1'b1, "R7 failed copy row closed");
    query(16'hFFC0, 1'b0, "R7 refused destination open");
    // R8 erase block of 0x0460 (block 0x23)
    @(negedge clk);
    erase_valid = 1'b1; erase_row = 16'h0470;
    @(negedge clk);
    erase_valid = 1'b0;
    query(16'h0460, 1'b0, "R8 erased block reopened");
    query(16'h5A1F, 1'b1, "R8 other block still closed");

    // R6 timeout
    stuck = 1'b1; busy_len = 5;
    start_req(16'h0101, 16'h0202);
    wait_done(got);
    chk(got && err_timeout, "R6 timeout flagged", err_timeout, 1);
    repeat (20) @(negedge clk);
    chk(wcount == 4 && re_pulses == 0, "R6 no program after timeout", wcount, 4);
    stuck = 1'b0;

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule